// File: doc/BRIEF.md
# Strided Block Access Serializer

This block takes one vector operand access (eight 32-byte blocks described by a start address and a block stride) and schedules it against a banked scratchpad of 192 KB. The scratchpad holds 48 banks of 128 rows of 32 bytes each. The banks are arranged as 16 groups of three, and group g holds banks g, g+16 and g+32. In any cycle only one row per group may be touched. The serializer maps every block to its bank, group and row. Each cycle it issues a subset of the pending blocks in which no two blocks share a group. When the last block has gone out it pulses done together with the number of cycles the access took.

A requester presents the operand on a valid/ready handshake. While the access is in flight the requester sees ready low. Per-block strobes, each with a bank index and a row index, drive the bank ports of the memory. The data path and the memory array sit outside this block.

Top module: `bsa_serializer`

## Requirements
- R1: A block at byte address A lies in bank 16*(A>>16) + ((A>>5) mod 16) and in group (A>>5) mod 16. For example, 0x10000 maps to bank 16, 0x10020 to bank 17 and 0x20020 to bank 33.
- R2: The row reported for a block is (A mod 65536) >> 9, a value from 0 to 127.
- R3: Block i of a request lies at start + i*stride*32. The start is 32-byte aligned and below 192 KB, and a block address at or above 192 KB wraps back by 192 KB.
- R4: In any cycle, no two issued blocks belong to the same group.
- R5: When blocks compete for one group, the lowest-numbered pending block issues first. Block i therefore issues in the cycle that equals the number of lower-numbered blocks sharing its group, counted from 0 at the first issue cycle. Bit i of iss_valid marks block i.
- R6: The cycle count reported on done_cycles equals the largest number of blocks that share one group. Start 0x1FE00 with stride 16 gives 8, start 0x1FE00 with stride 8 gives 4, and stride 1 gives 1.
- R7: Each block of a request issues exactly once. iss_write equals the read/write flag of the request (1 = write).
- R8: The first issue cycle follows the accepting clock edge. done is high for exactly one cycle, the cycle after the last issue. req_ready is low from acceptance through the done cycle and returns high the cycle after done.
- R9: After a synchronous reset, req_ready is 1, done is 0 and no block issues. This holds even when the reset hits an access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Serializer idle, accepts a request |
| req_addr | input | 18 | Byte start address, 32-byte aligned |
| req_stride | input | 8 | Block stride in 32-byte units |
| req_write | input | 1 | 1 = write access, 0 = read |
| iss_valid | output | 8 | Per-block issue strobe, bit i = block i |
| iss_bank | output | 48 | Bank of block i in bits [6i+5:6i] |
| iss_row | output | 56 | Row of block i in bits [7i+6:7i] |
| iss_write | output | 1 | Direction of the access in flight |
| done | output | 1 | One-cycle pulse after the last issue |
| done_cycles | output | 4 | Issue cycles used, valid with done |

## Verification
A corrupted pending mask shows at the ports within one cycle. A block either reappears on iss_valid or goes missing from the expected schedule, and done then arrives early or late with a wrong cycle count. A wrong group or bank mapping shows in the very first issue cycle, as a wrong bank or row field or as two same-group strobes together. A stuck control state shows as req_ready failing to return the cycle after done. The bench compares every issue cycle against a schedule it computes itself, so each of these faults is caught in the cycle where it occurs.

// File: rtl/bsa_pkg.sv
// Package: shared defaults and the control state type of the serializer.
// Assumes groups, rows and block size are powers of two.
package bsa_pkg;
    localparam int DEF_BLOCKS      = 8;
    localparam int DEF_GROUPS      = 16;
    localparam int DEF_GROUP_BANKS = 3;
    localparam int DEF_ROWS        = 128;
    localparam int DEF_BLK_BYTES   = 32;
    localparam int DEF_STRIDE_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } bsa_state_t;
endpackage

// File: rtl/bsa_block_map.sv
// Module: bsa_block_map
// Computes, for every block of one operand, its bank, row and group.
// Works in 32-byte block units: blk = start + i*stride, wrapped once by
// the buffer size. Assumes (BLOCKS-1)*(2^STRIDE_W-1) < buffer blocks, so
// a single conditional subtract is enough.
module bsa_block_map #(
    parameter int BLOCKS    = 8,
    parameter int IDX_W     = 13,
    parameter int STRIDE_W  = 8,
    parameter int GRP_W     = 4,
    parameter int ROW_W     = 7,
    parameter int BANK_W    = 6,
    parameter int BUF_BLKS  = 6144
) (
    input  logic [IDX_W-1:0]           base_blk,
    input  logic [STRIDE_W-1:0]        stride,
    output logic [BLOCKS*BANK_W-1:0]   bank,
    output logic [BLOCKS*ROW_W-1:0]    row,
    output logic [BLOCKS*GRP_W-1:0]    group
);
    localparam int SUM_W = IDX_W + 1;
    localparam int SEG_W = BANK_W - GRP_W;
    localparam logic [SUM_W-1:0] WRAP = SUM_W'(BUF_BLKS);

    for (genvar i = 0; i < BLOCKS; i++) begin : g_blk
        localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
        logic [SUM_W-1:0] sum;
        logic [IDX_W-1:0] blk;

        // Block index: base plus i strides, folded back into the buffer (R3).
        always_comb begin
            sum = {1'b0, base_blk} + IDX * {{(SUM_W-STRIDE_W){1'b0}}, stride};
            blk = (sum >= WRAP) ? IDX_W'(sum - WRAP) : IDX_W'(sum);
        end

        // Split the block index: group low, row middle, segment high (R1, R2).
        always_comb begin
            group[i*GRP_W +: GRP_W]  = blk[GRP_W-1:0];
            row[i*ROW_W +: ROW_W]    = blk[GRP_W +: ROW_W];
            bank[i*BANK_W +: BANK_W] = {blk[IDX_W-1 -: SEG_W], blk[GRP_W-1:0]};
        end
    end
endmodule

// File: rtl/bsa_group_pick.sv
// Module: bsa_group_pick
// Chooses, among pending blocks, the lowest-numbered one of every group.
// Purely combinational; clk/rst_n serve only the embedded checks.
module bsa_group_pick #(
    parameter int BLOCKS = 8,
    parameter int GROUPS = 16,
    parameter int GRP_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BLOCKS-1:0]         pending,
    input  logic [BLOCKS*GRP_W-1:0]   group,
    output logic [BLOCKS-1:0]         grant
);
    for (genvar i = 0; i < BLOCKS; i++) begin : g_pick
        // Grant block i unless a lower pending block shares its group (R5).
        always_comb begin
            grant[i] = pending[i];
            for (int j = 0; j < i; j++) begin
                if (pending[j] && group[j*GRP_W +: GRP_W] == group[i*GRP_W +: GRP_W])
                    grant[i] = 1'b0;
            end
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        logic [BLOCKS-1:0] in_grp;
        // Collect grants that fall in group g for the per-group check.
        always_comb begin
            for (int i = 0; i < BLOCKS; i++)
                in_grp[i] = grant[i] && (group[i*GRP_W +: GRP_W] == GRP_W'(g));
        end
        // R4: never two grants in one group.
        assert_one_per_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(in_grp));
    end

    // R6: any pending work makes progress every cycle.
    assert_progress_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> (grant != '0));
    // R7: only pending blocks are granted.
    assert_grant_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pending) == '0);
endmodule

// File: rtl/bsa_serializer.sv
// Module: bsa_serializer (top)
// Accepts one strided eight-block operand access, issues its blocks over as
// many cycles as the busiest bank group needs, then pulses done with the
// cycle count. Assumes a 32-byte aligned start below the buffer size.
module bsa_serializer
    import bsa_pkg::*;
#(
    parameter int BLOCKS      = DEF_BLOCKS,
    parameter int GROUPS      = DEF_GROUPS,
    parameter int GROUP_BANKS = DEF_GROUP_BANKS,
    parameter int ROWS        = DEF_ROWS,
    parameter int BLK_BYTES   = DEF_BLK_BYTES,
    parameter int STRIDE_W    = DEF_STRIDE_W,
    localparam int BANKS      = GROUPS * GROUP_BANKS,
    localparam int GRP_W      = $clog2(GROUPS),
    localparam int ROW_W      = $clog2(ROWS),
    localparam int BLK_SH     = $clog2(BLK_BYTES),
    localparam int BUF_BLKS   = BANKS * ROWS,
    localparam int ADDR_W     = $clog2(BUF_BLKS * BLK_BYTES),
    localparam int IDX_W      = ADDR_W - BLK_SH,
    localparam int BANK_W     = $clog2(BANKS),
    localparam int CNT_W      = $clog2(BLOCKS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [STRIDE_W-1:0]       req_stride,
    input  logic                      req_write,
    output logic [BLOCKS-1:0]         iss_valid,
    output logic [BLOCKS*BANK_W-1:0]  iss_bank,
    output logic [BLOCKS*ROW_W-1:0]   iss_row,
    output logic                      iss_write,
    output logic                      done,
    output logic [CNT_W-1:0]          done_cycles
);
    bsa_state_t             state_q;
    logic [IDX_W-1:0]       base_q;
    logic [STRIDE_W-1:0]    stride_q;
    logic                   write_q;
    logic [BLOCKS-1:0]      pending_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       cycles_q;
    logic [BLOCKS*GRP_W-1:0] grp;
    logic [BLOCKS-1:0]      grant;
    logic [BLOCKS-1:0]      pending_nx;

    bsa_block_map #(
        .BLOCKS(BLOCKS), .IDX_W(IDX_W), .STRIDE_W(STRIDE_W), .GRP_W(GRP_W),
        .ROW_W(ROW_W), .BANK_W(BANK_W), .BUF_BLKS(BUF_BLKS)
    ) u_map (
        .base_blk(base_q), .stride(stride_q),
        .bank(iss_bank), .row(iss_row), .group(grp)
    );

    bsa_group_pick #(
        .BLOCKS(BLOCKS), .GROUPS(GROUPS), .GRP_W(GRP_W)
    ) u_pick (
        .clk(clk), .rst_n(rst_n), .pending(pending_q), .group(grp), .grant(grant)
    );

    // Blocks still waiting after this cycle's grants.
    assign pending_nx = pending_q & ~grant;

    // Control sequence: accept, issue until empty, pulse done (R8, R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            base_q    <= '0;
            stride_q  <= '0;
            write_q   <= 1'b0;
            pending_q <= '0;
            cnt_q     <= '0;
            cycles_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    base_q    <= req_addr[ADDR_W-1:BLK_SH];
                    stride_q  <= req_stride;
                    write_q   <= req_write;
                    pending_q <= '1;
                    cnt_q     <= '0;
                    state_q   <= ST_BUSY;
                end
                ST_BUSY: begin
                    pending_q <= pending_nx;
                    cnt_q     <= cnt_q + 1'b1;
                    if (pending_nx == '0) begin
                        cycles_q <= cnt_q + 1'b1;
                        state_q  <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the control state.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        iss_valid   = (state_q == ST_BUSY) ? grant : '0;
        iss_write   = write_q;
        done        = (state_q == ST_DONE);
        done_cycles = cycles_q;
    end

    // R3: start addresses are block aligned.
    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[BLK_SH-1:0] == '0));
    // R8: done lasts one cycle and is followed by ready.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    // R8: an idle serializer issues nothing and signals nothing.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (iss_valid == '0 && !done));
    // R6: reported cycle count lies between 1 and BLOCKS.
    assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_cycles >= CNT_W'(1) && done_cycles <= CNT_W'(BLOCKS)));
    // R7: direction holds steady across one access.
    assert_dir_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid != '0 && !$past(req_ready)) |-> $stable(iss_write));
    // R1: every issued bank index is inside the array.
    for (genvar i = 0; i < BLOCKS; i++) begin : g_bank_chk
        assert_bank_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[i] |-> (iss_bank[i*BANK_W +: BANK_W] < BANK_W'(BANKS)));
    end
endmodule

// File: tb/bsa_serializer_tb.sv
module bsa_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    localparam int VA[NV] = '{32'h1FE00, 32'h1FE00, 32'h10000, 32'h10020, 32'h2FF00, 32'h00020, 32'h00000};
    localparam int VS[NV] = '{16, 8, 1, 0, 4, 2, 3};
    localparam bit VW[NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int VC[NV] = '{8, 4, 1, 8, 2, 1, 1};

    logic clk = 0, rst_n = 0, req_valid = 0, req_write = 0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_stride = '0;
    logic req_ready, iss_write, done;
    logic [7:0] iss_valid;
    logic [47:0] iss_bank;
    logic [55:0] iss_row;
    logic [3:0] done_cycles;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsa_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_stride(req_stride), .req_write(req_write),
        .iss_valid(iss_valid), .iss_bank(iss_bank), .iss_row(iss_row),
        .iss_write(iss_write), .done(done), .done_cycles(done_cycles)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Issue one request and follow it cycle by cycle against a bench-side schedule.
    task automatic run_case(input int a, input int s, input bit w, input int exp_cyc);
        int eb[8], er[8], sched[8];
        int ncyc = 0, guard = 0;
        logic [7:0] seen = '0;
        for (int i = 0; i < 8; i++) begin
            int blk = (a / 32 + i * s) % 6144;      // R3 wrap at 192 KB
            eb[i] = (blk / 2048) * 16 + blk % 16;   // R1
            er[i] = (blk / 16) % 128;               // R2
            sched[i] = 0;
            for (int j = 0; j < i; j++) begin
                int bj = (a / 32 + j * s) % 6144;
                if (bj % 16 == blk % 16) sched[i]++;
            end
            if (sched[i] + 1 > ncyc) ncyc = sched[i] + 1;
        end
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        req_valid = 1; req_addr = 18'(a); req_stride = 8'(s); req_write = w;
        @(negedge clk);
        req_valid = 0;
        for (int c = 0; c < ncyc; c++) begin
            logic [7:0] m = '0;
            for (int i = 0; i < 8; i++) if (sched[i] == c) m[i] = 1'b1;
            chk(iss_valid == m, "R5 issue mask (R4 groups)", int'(iss_valid), int'(m));
            for (int i = 0; i < 8; i++) if (m[i] && iss_valid[i]) begin
                chk(int'(iss_bank[i*6 +: 6]) == eb[i], "R1 bank", int'(iss_bank[i*6 +: 6]), eb[i]);
                chk(int'(iss_row[i*7 +: 7]) == er[i], "R2 row", int'(iss_row[i*7 +: 7]), er[i]);
                chk(iss_write == w, "R7 direction", int'(iss_write), int'(w));
            end
            seen = seen | iss_valid;
            chk(!req_ready && !done, "R8 busy handshake", int'({req_ready, done}), 0);
            @(negedge clk);
        end
        chk(seen == 8'hFF, "R7 all blocks once", int'(seen), 255);
        chk(done == 1'b1 && iss_valid == 0, "R8 done pulse", int'(done), 1);
        chk(int'(done_cycles) == exp_cyc, "R6 cycle count", int'(done_cycles), exp_cyc);
        chk(!req_ready, "R8 ready low on done", int'(req_ready), 0);
        @(negedge clk);
        chk(req_ready && !done, "R8 ready after done", int'({req_ready, done}), 2);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(req_ready == 1 && iss_valid == 0 && done == 0, "R9 reset state",
            int'({req_ready, done}), 2);
        rst_n = 1;
        @(negedge clk);
        for (int k = 0; k < NV; k++) run_case(VA[k], VS[k], VW[k], VC[k]);

        // R9: reset in the middle of an access returns to idle
        req_valid = 1; req_addr = 18'h1FE00; req_stride = 8'd16; req_write = 0;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk(iss_valid == 8'h02, "R5 second cycle of conflict run", int'(iss_valid), 2);
        rst_n = 0;
        @(negedge clk);
        chk(req_ready && iss_valid == 0 && !done, "R9 mid-run reset",
            int'({req_ready, done}), 2);
        rst_n = 1;
        @(negedge clk);
        // R3: wrap case again after reset
        run_case(32'h2FF00, 4, 1'b1, 2);
        run_case(32'h1FE00, 8, 1'b0, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule